// File: doc/BRIEF.md
# Time-Slotted Channel-Hopping Slot Sequencer

This block drives one timeslot at a time for a node on a slotted, channel-hopping link. At the first tick of every slot it reads the role that the schedule gives for the current absolute slot number: sleep, transmit or listen. It then runs the exchange of that slot. On the transmit side it asks an external security engine to protect the data frame, starts the radio at a fixed offset, waits for an acknowledgment and asks for that acknowledgment to be verified. On the listen side it waits for the end of a data frame, has it verified, has an acknowledgment protected, and starts the radio a fixed delay after the data frame ended.

One tick is one clock cycle. The slot length, the transmit offset, the acknowledgment delay, the acknowledgment guard time and the budget allowed for acknowledgment verification are programmable. They take effect only at a slot boundary. The data window and the acknowledgment window are parameters given in nanoseconds. They are turned into ticks using the tick length parameter. The 40-bit absolute slot number is exported so that the security engine can form its nonce. The security engine and the radio answer with one-cycle done, fail, start-of-frame and end-of-frame pulses. If a security step misses the instant at which the radio must start, the slot is aborted and a flag for that step is raised.

Top module: `tsch_slot_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the slot number is 0 and every request, radio and result output is low.
- R2: The slot counter resets to 0 and increments by exactly 1 on the last tick of every slot. Ticks run 0 to L-1, where L is the slot length latched for that slot.
- R3: Slot length, transmit offset, acknowledgment delay, guard time and verification budget are sampled only at a slot boundary or in reset. A change made mid-slot shows from the next slot on.
- R4: The role input is sampled at tick 0 (00 sleep, 01 transmit, 10 listen, 11 treated as sleep). In a sleep slot no security request, radio start or receive enable is issued.
- R5: As transmitter, a security request with operation code 0 (protect data) is high from tick 1. When done arrives at any tick up to transmit-offset minus 1, radio_tx_start pulses for one cycle exactly at the tick equal to the transmit offset, with radio_tx_ack low.
- R6: If the data-protect done has not arrived by transmit-offset minus 1, no transmission starts. At the transmit-offset tick, ovr bit 0 and slot_err pulse, and a later done is ignored.
- R7: After the acknowledgment start and end pulses, a request with operation code 3 (verify acknowledgment) is raised. Done makes q_pop and tcorr_apply pulse on the next tick. Fail makes tx_fail pulse instead, and the frame is not popped.
- R8: If no acknowledgment start arrives by tick offset+W_TX+delay+guard, where W_TX is the data window in ticks, tx_fail pulses on the following tick and the receive enable drops.
- R9: If acknowledgment verification is still pending at the slot's last tick, ovr bit 3 and slot_err pulse at tick 0 of the next slot, and the frame is not popped.
- R10: As listener, an end-of-frame pulse at tick E raises operation code 1 (verify data) at E+1. Done raises operation code 2 (protect acknowledgment). When that finishes by tick E+delay-1, radio_tx_start and radio_tx_ack pulse exactly at tick E+delay.
- R11: If data verification fails, no acknowledgment is protected and none is transmitted.
- R12: At tick E+delay, ovr bit 1 pulses if data verification is still pending, or ovr bit 2 pulses if acknowledgment protection is still pending. In both cases slot_err pulses and no acknowledgment is sent.
- R13: cfg_viol is high exactly when the latched slot length is below offset + W_TX + delay + W_ACK + verification budget, where W_TX and W_ACK are the floors of the window times divided by the tick length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one tick |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slot_len | input | TW | Slot length in ticks |
| cfg_tx_offset | input | TW | Tick at which the data frame is launched |
| cfg_ack_delay | input | TW | Ticks from data end to acknowledgment start |
| cfg_ack_guard | input | TW | Extra ticks allowed for the acknowledgment start |
| cfg_ack_unsec | input | TW | Tick budget for acknowledgment verification |
| sched_role | input | 2 | Role of the current slot, sampled at tick 0 |
| sec_done | input | 1 | Security step completed (pulse) |
| sec_fail | input | 1 | Security step failed (pulse) |
| rx_sof | input | 1 | Start of received frame (pulse) |
| rx_eof | input | 1 | End of received frame (pulse) |
| asn | output | AW | Absolute slot number |
| cfg_viol | output | 1 | Latched timing set cannot fit in the slot |
| sec_req | output | 1 | Security engine request, held while pending |
| sec_op | output | 2 | Requested security operation |
| radio_rx_en | output | 1 | Receiver enable |
| radio_tx_start | output | 1 | Radio transmit start pulse |
| radio_tx_ack | output | 1 | The started transmission is an acknowledgment |
| q_pop | output | 1 | Remove the sent frame from the queue |
| tcorr_apply | output | 1 | Apply the time correction carried in the acknowledgment |
| tx_fail | output | 1 | Transmit attempt failed, frame kept |
| slot_err | output | 1 | A security step overran its window |
| ovr | output | 4 | Per-step overrun flags, bit index equals operation code |

## Verification
The assertions assume that the security engine sends done and fail as single-cycle pulses and never both at once. They also assume that the frame start and end pulses are single cycles, and that the programmed transmit offset and acknowledgment delay are at least 2 ticks. The stimulus raises each of these inputs for exactly one tick. A late done, sent after its step was abandoned, still stays a single pulse. All offsets used by the stimulus stay well inside the slot. The window-boundary sweeps put the late pulses one tick past the deadline, not further.

// File: rtl/tsch_seq_pkg.sv
package tsch_seq_pkg;

  typedef enum logic [1:0] {
    ROLE_SLEEP = 2'b00,
    ROLE_TX    = 2'b01,
    ROLE_RX    = 2'b10,
    ROLE_RSV   = 2'b11
  } slot_role_e;

  typedef enum logic [1:0] {
    OP_SEC_DATA   = 2'd0,
    OP_UNSEC_DATA = 2'd1,
    OP_SEC_ACK    = 2'd2,
    OP_UNSEC_ACK  = 2'd3
  } sec_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TX_SEC,
    S_TX_WAIT_OFF,
    S_TX_WAIT_ACK,
    S_TX_ACK_RX,
    S_TX_UNSEC,
    S_RX_LISTEN,
    S_RX_UNSEC,
    S_RX_SECACK,
    S_RX_WAIT_ACKTX,
    S_DONE
  } slot_state_e;

endpackage

// File: rtl/tsch_cfg_latch.sv
module tsch_cfg_latch #(
  parameter int TW            = 16,
  parameter int MAX_TX_TICKS  = 4256,
  parameter int MAX_ACK_TICKS = 2400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] in_len,
  input  logic [TW-1:0] in_off,
  input  logic [TW-1:0] in_dly,
  input  logic [TW-1:0] in_guard,
  input  logic [TW-1:0] in_unsec,
  output logic [TW-1:0] q_len,
  output logic [TW-1:0] q_off,
  output logic [TW-1:0] q_dly,
  output logic [TW-1:0] q_guard,
  output logic          cfg_viol
);
  localparam int SW = TW + 3;
  localparam logic [SW-1:0] W_TX  = SW'(MAX_TX_TICKS);
  localparam logic [SW-1:0] W_ACK = SW'(MAX_ACK_TICKS);

  logic [SW-1:0] need;
  logic          short_slot;

  // Minimum slot: offset, data window, turnaround, ack window, ack check
  assign need       = SW'(in_off) + W_TX + SW'(in_dly) + W_ACK + SW'(in_unsec);
  assign short_slot = SW'(in_len) < need;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      q_len    <= in_len;
      q_off    <= in_off;
      q_dly    <= in_dly;
      q_guard  <= in_guard;
      cfg_viol <= short_slot;
    end
  end
endmodule

// File: rtl/tsch_slot_timer.sv
module tsch_slot_timer #(
  parameter int TW = 16,
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] slot_len,
  output logic [TW-1:0] tick,
  output logic          last,
  output logic [AW-1:0] asn
);
  // A zero length behaves like a one-tick slot
  assign last = ({1'b0, tick} + (TW+1)'(1)) >= {1'b0, slot_len};

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= '0;
      asn  <= '0;
    end else if (last) begin
      tick <= '0;
      asn  <= asn + AW'(1);
    end else begin
      tick <= tick + TW'(1);
    end
  end
endmodule

// File: rtl/tsch_slot_fsm.sv
module tsch_slot_fsm
  import tsch_seq_pkg::*;
#(
  parameter int TW           = 16,
  parameter int MAX_TX_TICKS = 4256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tick,
  input  logic          last,
  input  logic [1:0]    role,
  input  logic [TW-1:0] tx_off,
  input  logic [TW-1:0] ack_dly,
  input  logic [TW-1:0] ack_guard,
  input  logic          sec_done,
  input  logic          sec_fail,
  input  logic          rx_sof,
  input  logic          rx_eof,
  output logic          sec_req,
  output logic [1:0]    sec_op,
  output logic          radio_rx_en,
  output logic          radio_tx_start,
  output logic          radio_tx_ack,
  output logic          q_pop,
  output logic          tcorr_apply,
  output logic          tx_fail,
  output logic          slot_err,
  output logic [3:0]    ovr
);
  localparam int DW = TW + 2;
  localparam logic [DW-1:0] W_TX = DW'(MAX_TX_TICKS);

  slot_state_e   state;
  logic [DW-1:0] tick_w, tick_n, off_w, ack_at, deadline;

  assign tick_w   = DW'(tick);
  assign tick_n   = tick_w + DW'(1);
  assign off_w    = DW'(tx_off);
  assign deadline = off_w + W_TX + DW'(ack_dly) + DW'(ack_guard);

  always_comb begin
    sec_req     = 1'b0;
    sec_op      = OP_SEC_DATA;
    radio_rx_en = 1'b0;
    case (state)
      S_TX_SEC:    begin sec_req = 1'b1; sec_op = OP_SEC_DATA;   end
      S_TX_UNSEC:  begin sec_req = 1'b1; sec_op = OP_UNSEC_ACK;  end
      S_RX_UNSEC:  begin sec_req = 1'b1; sec_op = OP_UNSEC_DATA; end
      S_RX_SECACK: begin sec_req = 1'b1; sec_op = OP_SEC_ACK;    end
      S_TX_WAIT_ACK, S_TX_ACK_RX, S_RX_LISTEN: radio_rx_en = 1'b1;
      default: ;
    endcase
  end

  // Registered pulses are set one tick ahead (tick_n) so they land on the target tick
  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= S_IDLE;
      ack_at         <= '0;
      radio_tx_start <= 1'b0;
      radio_tx_ack   <= 1'b0;
      q_pop          <= 1'b0;
      tcorr_apply    <= 1'b0;
      tx_fail        <= 1'b0;
      slot_err       <= 1'b0;
      ovr            <= '0;
    end else begin
      radio_tx_start <= 1'b0;
      radio_tx_ack   <= 1'b0;
      q_pop          <= 1'b0;
      tcorr_apply    <= 1'b0;
      tx_fail        <= 1'b0;
      slot_err       <= 1'b0;
      ovr            <= '0;
      case (state)
        S_IDLE: begin
          if (tick == '0) begin
            if (role == ROLE_TX)      state <= S_TX_SEC;
            else if (role == ROLE_RX) state <= S_RX_LISTEN;
            else                      state <= S_DONE;
          end
        end
        S_TX_SEC: begin
          if (sec_fail) begin
            tx_fail <= 1'b1;
            state   <= S_DONE;
          end else if (sec_done) begin
            if (tick_n >= off_w) begin
              radio_tx_start <= 1'b1;
              state          <= S_TX_WAIT_ACK;
            end else begin
              state <= S_TX_WAIT_OFF;
            end
          end else if (tick_n >= off_w) begin
            ovr[OP_SEC_DATA] <= 1'b1;
            slot_err         <= 1'b1;
            state            <= S_DONE;
          end
        end
        S_TX_WAIT_OFF: begin
          if (tick_n >= off_w) begin
            radio_tx_start <= 1'b1;
            state          <= S_TX_WAIT_ACK;
          end
        end
        S_TX_WAIT_ACK: begin
          if (rx_sof) begin
            state <= S_TX_ACK_RX;
          end else if (tick_w >= deadline) begin
            tx_fail <= 1'b1;
            state   <= S_DONE;
          end
        end
        S_TX_ACK_RX: begin
          if (rx_eof) state <= S_TX_UNSEC;
        end
        S_TX_UNSEC: begin
          if (sec_done) begin
            q_pop       <= 1'b1;
            tcorr_apply <= 1'b1;
            state       <= S_DONE;
          end else if (sec_fail) begin
            tx_fail <= 1'b1;
            state   <= S_DONE;
          end else if (last) begin
            ovr[OP_UNSEC_ACK] <= 1'b1;
            slot_err          <= 1'b1;
          end
        end
        S_RX_LISTEN: begin
          if (rx_eof) begin
            ack_at <= tick_w + DW'(ack_dly);
            state  <= S_RX_UNSEC;
          end
        end
        S_RX_UNSEC: begin
          if (sec_fail) begin
            state <= S_DONE;
          end else if (sec_done) begin
            if (tick_n >= ack_at) begin
              ovr[OP_SEC_ACK] <= 1'b1;
              slot_err        <= 1'b1;
              state           <= S_DONE;
            end else begin
              state <= S_RX_SECACK;
            end
          end else if (tick_n >= ack_at) begin
            ovr[OP_UNSEC_DATA] <= 1'b1;
            slot_err           <= 1'b1;
            state              <= S_DONE;
          end
        end
        S_RX_SECACK: begin
          if (sec_fail) begin
            state <= S_DONE;
          end else if (sec_done) begin
            if (tick_n >= ack_at) begin
              radio_tx_start <= 1'b1;
              radio_tx_ack   <= 1'b1;
              state          <= S_DONE;
            end else begin
              state <= S_RX_WAIT_ACKTX;
            end
          end else if (tick_n >= ack_at) begin
            ovr[OP_SEC_ACK] <= 1'b1;
            slot_err        <= 1'b1;
            state           <= S_DONE;
          end
        end
        S_RX_WAIT_ACKTX: begin
          if (tick_n >= ack_at) begin
            radio_tx_start <= 1'b1;
            radio_tx_ack   <= 1'b1;
            state          <= S_DONE;
          end
        end
        default: ;
      endcase
      if (last) state <= S_IDLE;
    end
  end
endmodule

// File: rtl/tsch_slot_seq.sv
module tsch_slot_seq #(
  parameter int TW         = 16,
  parameter int AW         = 40,
  parameter int TICK_NS    = 1000,
  parameter int TX_WIN_NS  = 4256000,
  parameter int ACK_WIN_NS = 2400000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] cfg_slot_len,
  input  logic [TW-1:0] cfg_tx_offset,
  input  logic [TW-1:0] cfg_ack_delay,
  input  logic [TW-1:0] cfg_ack_guard,
  input  logic [TW-1:0] cfg_ack_unsec,
  input  logic [1:0]    sched_role,
  input  logic          sec_done,
  input  logic          sec_fail,
  input  logic          rx_sof,
  input  logic          rx_eof,
  output logic [AW-1:0] asn,
  output logic          cfg_viol,
  output logic          sec_req,
  output logic [1:0]    sec_op,
  output logic          radio_rx_en,
  output logic          radio_tx_start,
  output logic          radio_tx_ack,
  output logic          q_pop,
  output logic          tcorr_apply,
  output logic          tx_fail,
  output logic          slot_err,
  output logic [3:0]    ovr
);
  localparam int MAX_TX_TICKS  = TX_WIN_NS / TICK_NS;
  localparam int MAX_ACK_TICKS = ACK_WIN_NS / TICK_NS;

  logic [TW-1:0] len_q, off_q, dly_q, guard_q, tick;
  logic          last;

  tsch_cfg_latch #(
    .TW(TW), .MAX_TX_TICKS(MAX_TX_TICKS), .MAX_ACK_TICKS(MAX_ACK_TICKS)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(last),
    .in_len(cfg_slot_len), .in_off(cfg_tx_offset), .in_dly(cfg_ack_delay),
    .in_guard(cfg_ack_guard), .in_unsec(cfg_ack_unsec),
    .q_len(len_q), .q_off(off_q), .q_dly(dly_q), .q_guard(guard_q),
    .cfg_viol(cfg_viol)
  );

  tsch_slot_timer #(.TW(TW), .AW(AW)) u_timer (
    .clk(clk), .rst(rst), .slot_len(len_q),
    .tick(tick), .last(last), .asn(asn)
  );

  tsch_slot_fsm #(.TW(TW), .MAX_TX_TICKS(MAX_TX_TICKS)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .last(last), .role(sched_role),
    .tx_off(off_q), .ack_dly(dly_q), .ack_guard(guard_q),
    .sec_done(sec_done), .sec_fail(sec_fail), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .sec_req(sec_req), .sec_op(sec_op), .radio_rx_en(radio_rx_en),
    .radio_tx_start(radio_tx_start), .radio_tx_ack(radio_tx_ack),
    .q_pop(q_pop), .tcorr_apply(tcorr_apply), .tx_fail(tx_fail),
    .slot_err(slot_err), .ovr(ovr)
  );
endmodule

// File: rtl/tsch_slot_seq_chk.sv
module tsch_slot_seq_chk #(
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst,
  input logic          radio_tx_start,
  input logic          q_pop,
  input logic          tx_fail,
  input logic          slot_err,
  input logic          sec_req,
  input logic          sec_done,
  input logic [1:0]    sec_op,
  input logic [3:0]    ovr,
  input logic [AW-1:0] asn
);
  assert_asn_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (asn == $past(asn) || asn == $past(asn) + AW'(1)));

  assert_launch_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    radio_tx_start |=> !radio_tx_start);

  assert_pop_after_check_R7: assert property (@(posedge clk) disable iff (rst)
    q_pop |-> $past(sec_req && sec_op == 2'd3 && sec_done));

  assert_single_outcome_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({q_pop, tx_fail, slot_err}));

  assert_one_overrun_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ovr));

  assert_overrun_flags_error_R6: assert property (@(posedge clk) disable iff (rst)
    (ovr != 4'd0) |-> slot_err);
endmodule

bind tsch_slot_seq tsch_slot_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .radio_tx_start(radio_tx_start), .q_pop(q_pop),
  .tx_fail(tx_fail), .slot_err(slot_err), .sec_req(sec_req),
  .sec_done(sec_done), .sec_op(sec_op), .ovr(ovr), .asn(asn)
);

// File: tb/tsch_slot_seq_tb.sv
module tsch_slot_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TW         = 16;
  localparam int AW         = 40;
  localparam int TICK_NS    = 250000;
  localparam int MTX        = 4256000 / TICK_NS;
  localparam int MACK       = 2400000 / TICK_NS;

  logic clk = 1'b0, rst = 1'b1;
  logic [TW-1:0] cfg_slot_len = 16'd60, cfg_tx_offset = 16'd6, cfg_ack_delay = 16'd5;
  logic [TW-1:0] cfg_ack_guard = 16'd3, cfg_ack_unsec = 16'd4;
  logic [1:0] sched_role = 2'b00;
  logic sec_done = 1'b0, sec_fail = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [AW-1:0] asn;
  logic cfg_viol, sec_req, radio_rx_en, radio_tx_start, radio_tx_ack;
  logic q_pop, tcorr_apply, tx_fail, slot_err;
  logic [1:0] sec_op;
  logic [3:0] ovr;

  tsch_slot_seq #(.TW(TW), .AW(AW), .TICK_NS(TICK_NS)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference slot clock from R2/R3
  int btick, blen, bofs, bdly, bunsec;
  longint basn;
  always @(posedge clk) begin
    if (rst || btick + 1 >= blen) begin
      btick  <= 0;
      basn   <= rst ? 0 : basn + 1;
      blen   <= cfg_slot_len;
      bofs   <= cfg_tx_offset;
      bdly   <= cfg_ack_delay;
      bunsec <= cfg_ack_unsec;
    end else btick <= btick + 1;
  end

  int nchk = 0, nfail = 0;
  bit mon_on = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h (asn %0d tick %0d)", tag, act, exp, basn, btick);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    chk("R2 slot number", asn, basn);
    chk("R13 cfg_viol", cfg_viol, (blen < bofs + MTX + bdly + MACK + bunsec));
  end

  task automatic at_tick(input int t);
    @(negedge clk);
    while (btick != t) @(negedge clk);
  endtask
  task automatic p_done(); sec_done = 1'b1; @(negedge clk); sec_done = 1'b0; endtask
  task automatic p_fail(); sec_fail = 1'b1; @(negedge clk); sec_fail = 1'b0; endtask
  task automatic p_sof();  rx_sof   = 1'b1; @(negedge clk); rx_sof   = 1'b0; endtask
  task automatic p_eof();  rx_eof   = 1'b1; @(negedge clk); rx_eof   = 1'b0; endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 asn", asn, 0);
    chk("R1 outputs", {sec_req, radio_rx_en, radio_tx_start, q_pop, tcorr_apply, tx_fail, slot_err, ovr}, 0);
    rst = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    chk("R1 after release", {sec_req, radio_rx_en, radio_tx_start, q_pop, tx_fail, slot_err}, 0);

    // R4: sleep and reserved roles stay silent all slot
    for (int r = 0; r < 4; r += 3) begin
      at_tick(0); sched_role = 2'(r);
      for (int t = 1; t < 60; t++) begin
        at_tick(t);
        chk("R4 silent slot", {sec_req, radio_rx_en, radio_tx_start}, 0);
      end
    end

    // R5/R6/R8: sweep the data-protect done tick across the launch deadline
    for (int d = 1; d <= 7; d++) begin
      at_tick(0); sched_role = 2'b01;
      at_tick(1);
      chk("R5 protect request", {sec_req, sec_op}, {1'b1, 2'd0});
      if (d == 1) p_done();
      else if (d <= 5) begin at_tick(d); p_done(); end
      if (btick != 6) at_tick(6);
      chk("R5 launch at offset", {radio_tx_start, radio_tx_ack}, {(d <= 5), 1'b0});
      chk("R6 overrun flag", {ovr, slot_err}, (d <= 5) ? 5'b0 : 5'b00011);
      if (d == 7) begin
        at_tick(7); p_done();
        chk("R6 late done ignored", {radio_tx_start, radio_rx_en}, 0);
      end
      if (d <= 5) begin
        at_tick(31); chk("R8 no timeout yet", tx_fail, 0);
        at_tick(32); chk("R8 ack timeout", {tx_fail, radio_rx_en, q_pop}, 3'b100);
      end
    end

    // R7/R8/R9: acknowledgment handling variants
    for (int v = 0; v < 4; v++) begin
      automatic int s = (v == 1) ? 31 : (v == 2) ? 32 : 28;
      at_tick(0); sched_role = 2'b01;
      at_tick(3); p_done();
      at_tick(6); chk("R5 launch", radio_tx_start, 1);
      if (v == 2) begin
        at_tick(32); chk("R8 timeout at guard end", tx_fail, 1);
        p_sof();
        chk("R8 late start ignored", {radio_rx_en, sec_req, q_pop}, 0);
      end else begin
        at_tick(s); p_sof();
        at_tick(35); p_eof();
        chk("R7 verify request", {sec_req, sec_op}, {1'b1, 2'd3});
        at_tick(38);
        if (v == 0) p_done();
        else if (v == 1) p_fail();
        else at_tick(39);
        chk("R7 outcome", {q_pop, tcorr_apply, tx_fail},
            (v == 0) ? 3'b110 : (v == 1) ? 3'b001 : 3'b000);
        if (v == 3) begin
          at_tick(0);
          chk("R9 verify overrun", {ovr, slot_err, q_pop}, 6'b100010);
        end
      end
    end

    // R10/R11/R12: listener, data end at tick 20, ack due at 25
    for (int i = 0; i < 5; i++) begin
      automatic int uk = (i < 3) ? 1 : (i == 3) ? 2 : 0;
      automatic int st = (i == 0) ? 23 : (i == 1) ? 24 : 25;
      automatic bit exp_ack = (uk == 1) && (st <= 24);
      at_tick(0); sched_role = 2'b10;
      at_tick(5); chk("R10 receiver on", radio_rx_en, 1);
      at_tick(20); p_eof();
      chk("R10 verify data request", {sec_req, sec_op}, {1'b1, 2'd1});
      if (uk != 0) begin
        at_tick(22);
        if (uk == 1) p_done(); else p_fail();
      end
      if (uk == 1) begin
        chk("R10 protect ack request", {sec_req, sec_op}, {1'b1, 2'd2});
        if (st == 23) p_done();
        else if (st == 24) begin at_tick(24); p_done(); end
      end
      if (uk == 2) chk("R11 no ack protect", sec_req, 0);
      if (btick != 25) at_tick(25);
      chk("R10 ack launch", {radio_tx_start, radio_tx_ack}, {exp_ack, exp_ack});
      chk("R12 overrun flags", {ovr, slot_err},
          (uk == 0) ? 5'b00101 : (uk == 1 && st == 25) ? 5'b01001 : 5'b0);
      if (uk == 1 && st == 25) begin
        p_done();
        chk("R12 late done ignored", radio_tx_start, 0);
      end
      if (uk == 2) begin
        at_tick(28); chk("R11 no ack sent", {radio_tx_start, sec_req}, 0);
      end
    end

    // R3: mid-slot change of offset and length
    at_tick(0); sched_role = 2'b01;
    at_tick(2); cfg_tx_offset = 16'd8; cfg_slot_len = 16'd50;
    at_tick(3); p_done();
    at_tick(6); chk("R3 old offset kept", radio_tx_start, 1);
    at_tick(0); sched_role = 2'b01;
    at_tick(3); p_done();
    at_tick(7); chk("R3 new offset not early", radio_tx_start, 0);
    at_tick(8); chk("R3 new offset used", radio_tx_start, 1);
    at_tick(33); chk("R8 deadline follows offset", tx_fail, 0);
    at_tick(34); chk("R8 deadline follows offset", tx_fail, 1);

    // R13: slot length at and below the minimum (8+MTX+5+MACK+4 = 43)
    at_tick(0); sched_role = 2'b00; cfg_slot_len = 16'd43;
    at_tick(1); chk("R13 old length", cfg_viol, 0);
    at_tick(0); cfg_slot_len = 16'd42;
    at_tick(1); chk("R13 exact fit", cfg_viol, 0);
    at_tick(0); cfg_slot_len = 16'd60; cfg_tx_offset = 16'd6;
    at_tick(1); chk("R13 one short", cfg_viol, 1);
    at_tick(0);
    at_tick(1); chk("R13 restored", cfg_viol, 0);

    mon_on = 1'b0;
    summary();
  end
endmodule